// File: doc/BRIEF.md
# Character Cell Dot Serializer

This block turns one row of a character glyph into the serial dot stream that drives a raster display. It runs on the dot clock. It divides that clock into character cells of 10 dots in wide-cell mode or 9 dots in narrow-cell mode. At the end of every cell it raises a one-cycle load strobe towards the font lookup. It takes the glyph byte offered in that same cycle and shifts it out one dot per clock, leftmost dot first.

A glyph row holds 7 visible dots. The cell positions after them are filled with blank dots. When the glyph byte asks for it, the last visible dot is stretched across those positions instead, so that line-drawing characters join up with their neighbours.

The cell mode can be changed at any time. The new width only applies from the next cell boundary, so a cell is never cut short or stretched. A character-clock strobe marks the first dot of each cell for the logic that steps through character addresses.

Top module: `glyph_dot_serializer`

## Requirements
- R1: With wide-cell mode latched (narrow_mode_i low at the previous load), font_load_o pulses once every 10 dot clocks.
- R2: With narrow-cell mode latched (narrow_mode_i high at the previous load), font_load_o pulses once every 9 dot clocks.
- R3: font_load_o is high for exactly one dot clock, on the last dot of a cell. In the next dot clock char_clk_o is high for that single cycle, and video_o shows dot 0 of the byte that was loaded.
- R4: The glyph byte is sampled only in the load cycle. Its bits 7 down to 1 appear on video_o as dots 0 to 6 of the cell, bit 7 first.
- R5: When bit 0 of the loaded byte is 0, every dot position from 7 to the end of the cell outputs 0.
- R6: When bit 0 of the loaded byte is 1, every dot position from 7 to the end of the cell repeats bit 1 of the byte.
- R7: narrow_mode_i is sampled only in the load cycle and sets the width of the cell that follows. Changing it in the middle of a cell leaves the length of that cell unchanged.
- R8: rst_n is synchronous and active low. One clock after it is sampled low, video_o, font_load_o and char_clk_o are all 0. After release the block runs a blank wide cell: font_load_o first rises on the 9th clock after release, whatever narrow_mode_i is, and video_o stays 0 until then.
- R9: Changes on glyph_i outside the load cycle have no effect on video_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_mode_i | input | 1 | 1 selects 9-dot cells, 0 selects 10-dot cells; sampled at load |
| glyph_i | input | 8 | Glyph row from font lookup: bits 7..1 are dots, bit 0 is the extend flag; valid while font_load_o is high |
| font_load_o | output | 1 | One-cycle strobe on the last dot of each cell; glyph_i is captured on this cycle |
| char_clk_o | output | 1 | One-cycle strobe on dot 0 of each cell |
| video_o | output | 1 | Serial video dot |

## Verification
The hardest case to reach from the ports is a mode or glyph change that lands inside a cell. Such a change must be ignored until the boundary, and then take effect exactly on the boundary. The stimulus locks onto the load strobe and reverses both narrow_mode_i and glyph_i at dot 3 of chosen cells. It then checks that the cell keeps its old length and dot pattern. A reset asserted part-way through a cell, with narrow mode requested, shows that the block restarts with a blank cell of wide length.

// File: rtl/dotser_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the character-cell dot serializer.
// Assumes a glyph row of 7 visible dots carried in an 8-bit font byte,
// with the spare least-significant bit used as the extend flag.
package dotser_pkg;

    localparam int FONT_BYTE_W = 8;   // width of one font row byte
    localparam int GLYPH_DOTS  = 7;   // visible dots per glyph row
    localparam int WIDE_CELL   = 10;  // dots per cell in wide mode
    localparam int NARROW_CELL = 9;   // dots per cell in narrow mode

    typedef enum logic {
        CELL_WIDE   = 1'b0,
        CELL_NARROW = 1'b1
    } cell_mode_e;

endpackage

// File: rtl/cell_timer.sv
`timescale 1ns/1ps
// Cell timer: counts dot clocks within a character cell and decodes the
// terminal count. The cell width is chosen by a mode register that is
// reloaded only on the terminal count, so a cell always completes at the
// width it started with.
// Assumes WIDE_CELL >= NARROW_CELL >= 2.
module cell_timer
    import dotser_pkg::*;
#(
    parameter int WIDE_W   = WIDE_CELL,
    parameter int NARROW_W = NARROW_CELL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic narrow_req_i,
    output logic term_o,
    output logic cell_start_o
);

    localparam int CW = $clog2(WIDE_W);
    localparam logic [CW-1:0] WIDE_LAST   = CW'(WIDE_W - 1);
    localparam logic [CW-1:0] NARROW_LAST = CW'(NARROW_W - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_idx;
    cell_mode_e    mode_q;
    logic          start_q;

    // Select the last dot index for the mode currently in force.
    always_comb begin
        last_idx = (mode_q == CELL_NARROW) ? NARROW_LAST : WIDE_LAST;
    end

    assign term_o = (cnt_q == last_idx);

    // Advance the dot counter, wrapping on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (term_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Take on a new cell mode only at a cell boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CELL_WIDE;
        end else if (term_o) begin
            mode_q <= narrow_req_i ? CELL_NARROW : CELL_WIDE;
        end
    end

    // Mark the first dot of each cell one clock after the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= term_o;
        end
    end

    assign cell_start_o = start_q;

endmodule

// File: rtl/cell_pattern_builder.sv
`timescale 1ns/1ps
// Cell pattern builder: expands one font byte into a full-width cell of
// dots, leftmost dot in the MSB. The upper GLYPH_DOTS bits of the byte
// become the glyph dots. The remaining cell positions are blank, or copies
// of the last glyph dot when the byte's extend flag (bit 0) is set.
// Assumes BYTE_W == GLYPH_DOTS + 1 and CELL_W >= GLYPH_DOTS.
module cell_pattern_builder
    import dotser_pkg::*;
#(
    parameter int BYTE_W = FONT_BYTE_W,
    parameter int GDOTS  = GLYPH_DOTS,
    parameter int CELL_W = WIDE_CELL
) (
    input  logic [BYTE_W-1:0] glyph_i,
    output logic [CELL_W-1:0] pattern_o
);

    localparam int PAD_DOTS = CELL_W - GDOTS;
    localparam int LAST_BIT = BYTE_W - GDOTS;   // byte bit of the last glyph dot

    logic extend;
    logic pad_dot;

    // Decide what fills the padding positions.
    always_comb begin
        extend  = glyph_i[0];
        pad_dot = extend & glyph_i[LAST_BIT];
    end

    // Place the glyph dots at the leftmost cell positions.
    for (genvar g = 0; g < GDOTS; g++) begin : g_glyph
        assign pattern_o[CELL_W-1-g] = glyph_i[BYTE_W-1-g];
    end

    // Fill the positions beyond the glyph.
    if (PAD_DOTS > 0) begin : g_pad
        for (genvar p = 0; p < PAD_DOTS; p++) begin : g_pos
            assign pattern_o[p] = pad_dot;
        end
    end

endmodule

// File: rtl/dot_shifter.sv
`timescale 1ns/1ps
// Dot shifter: loads a whole cell pattern on the load strobe and shifts
// it out MSB first, one dot per clock. The output dot is the register MSB,
// so dot 0 appears on the clock after the load.
// Assumes CELL_W >= 2.
module dot_shifter #(
    parameter int CELL_W = dotser_pkg::WIDE_CELL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CELL_W-1:0] pattern_i,
    output logic              dot_o
);

    logic [CELL_W-1:0] shreg_q;

    // Load a new cell or move the next dot into the output position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load_i) begin
            shreg_q <= pattern_i;
        end else begin
            shreg_q <= {shreg_q[CELL_W-2:0], 1'b0};
        end
    end

    assign dot_o = shreg_q[CELL_W-1];

endmodule

// File: rtl/glyph_dot_serializer.sv
`timescale 1ns/1ps
// Character-cell dot serializer top. Divides the dot clock into 10- or
// 9-dot cells, requests a glyph byte on the last dot of each cell and
// serializes it, padded to the cell width, into the video stream.
// Assumes the font lookup returns glyph_i in the same cycle that
// font_load_o is high.
module glyph_dot_serializer
    import dotser_pkg::*;
#(
    parameter int BYTE_W   = FONT_BYTE_W,
    parameter int GDOTS    = GLYPH_DOTS,
    parameter int WIDE_W   = WIDE_CELL,
    parameter int NARROW_W = NARROW_CELL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_mode_i,
    input  logic [BYTE_W-1:0] glyph_i,
    output logic              font_load_o,
    output logic              char_clk_o,
    output logic              video_o
);

    localparam int PAT_W = WIDE_W;   // pattern sized for the widest cell

    logic             term;
    logic [PAT_W-1:0] cell_pattern;

    cell_timer #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .narrow_req_i (narrow_mode_i),
        .term_o       (term),
        .cell_start_o (char_clk_o)
    );

    cell_pattern_builder #(
        .BYTE_W (BYTE_W),
        .GDOTS  (GDOTS),
        .CELL_W (PAT_W)
    ) u_builder (
        .glyph_i   (glyph_i),
        .pattern_o (cell_pattern)
    );

    dot_shifter #(
        .CELL_W (PAT_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (term),
        .pattern_i (cell_pattern),
        .dot_o     (video_o)
    );

    assign font_load_o = term;

endmodule

// File: rtl/dotser_checker.sv
`timescale 1ns/1ps
// Property checker for the dot serializer, bound to the top. It keeps its
// own record of the last loaded byte, the mode requested at that load and
// the dot position since the load. Against these it checks cell length,
// glyph order and padding.
module dotser_checker #(
    parameter int BYTE_W   = 8,
    parameter int GDOTS    = 7,
    parameter int WIDE_W   = 10,
    parameter int NARROW_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              narrow_mode_i,
    input logic [BYTE_W-1:0] glyph_i,
    input logic              font_load_o,
    input logic              char_clk_o,
    input logic              video_o
);

    localparam int PW = $clog2(WIDE_W) + 1;
    localparam logic [PW-1:0] POS_MAX     = '1;
    localparam logic [PW-1:0] WIDE_LAST   = PW'(WIDE_W - 1);
    localparam logic [PW-1:0] NARROW_LAST = PW'(NARROW_W - 1);
    localparam logic [PW-1:0] FIRST_PAD   = PW'(GDOTS);
    localparam int            LAST_BIT    = BYTE_W - GDOTS;

    logic [PW-1:0]     pos_q;
    logic [BYTE_W-1:0] glyph_q;
    logic              nmode_q;
    logic              seen_q;
    logic [BYTE_W-1:0] glyph_sh;

    // Record the loaded byte and mode, and count dots since the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            glyph_q <= '0;
            nmode_q <= 1'b0;
            seen_q  <= 1'b0;
        end else if (font_load_o) begin
            pos_q   <= '0;
            glyph_q <= glyph_i;
            nmode_q <= narrow_mode_i;
            seen_q  <= 1'b1;
        end else if (pos_q != POS_MAX) begin
            pos_q   <= pos_q + PW'(1);
        end
    end

    // Bring the expected glyph dot for the current position to the MSB.
    always_comb begin
        glyph_sh = glyph_q << pos_q;
    end

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        font_load_o |=> !font_load_o);                                          // R3
    AST_CHARCLK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        font_load_o |=> char_clk_o);                                            // R3
    AST_CHARCLK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        char_clk_o |-> $past(font_load_o));                                     // R3
    AST_WIDE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (font_load_o && seen_q && !nmode_q) |-> (pos_q == WIDE_LAST));          // R1
    AST_NARROW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (font_load_o && seen_q && nmode_q) |-> (pos_q == NARROW_LAST));         // R2
    AST_NO_SHORT_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pos_q < NARROW_LAST) |-> !font_load_o);                      // R7
    AST_GLYPH_DOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pos_q < FIRST_PAD) |-> (video_o == glyph_sh[BYTE_W-1]));     // R4
    AST_PAD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pos_q >= FIRST_PAD && !glyph_q[0]) |-> !video_o);            // R5
    AST_PAD_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pos_q >= FIRST_PAD && glyph_q[0])
            |-> (video_o == glyph_q[LAST_BIT]));                                // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!video_o && !font_load_o && !char_clk_o));                  // R8
    AST_BLANK_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !video_o);                                                  // R8

endmodule

bind glyph_dot_serializer dotser_checker #(
    .BYTE_W   (BYTE_W),
    .GDOTS    (GDOTS),
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .narrow_mode_i (narrow_mode_i),
    .glyph_i       (glyph_i),
    .font_load_o   (font_load_o),
    .char_clk_o    (char_clk_o),
    .video_o       (video_o)
);

// File: tb/sim_glyph_dot_serializer.sv
`timescale 1ns/1ps
// Bench for the dot serializer: a table of glyph/mode/expected-dot vectors
// walked cell by cell, then directed tests for mid-cell changes and reset.
module sim_glyph_dot_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       narrow_mode_i = 1'b0;
    logic [7:0] glyph_i = 8'h00;
    logic       font_load_o;
    logic       char_clk_o;
    logic       video_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    glyph_dot_serializer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .narrow_mode_i (narrow_mode_i),
        .glyph_i       (glyph_i),
        .font_load_o   (font_load_o),
        .char_clk_o    (char_clk_o),
        .video_o       (video_o)
    );

    // {glyph byte, narrow mode, expected dots with dot 0 in bit 9}
    localparam int NVEC = 9;
    localparam logic [18:0] VEC [NVEC] = '{
        {8'hFE, 1'b0, 10'h3F8},
        {8'hAA, 1'b1, 10'h2A8},
        {8'h03, 1'b0, 10'h00F},
        {8'h55, 1'b1, 10'h150},
        {8'h81, 1'b0, 10'h200},
        {8'hFF, 1'b1, 10'h3FF},
        {8'h92, 1'b0, 10'h248},
        {8'h02, 1'b1, 10'h008},
        {8'h0F, 1'b0, 10'h03F}
    };

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Entered on a negedge with font_load_o high; leaves on the next one.
    task automatic run_cell(input logic [7:0] g, input logic nm,
                            input logic [9:0] pat, input bit mid);
        int w = nm ? 9 : 10;
        glyph_i       = g;
        narrow_mode_i = nm;
        for (int d = 0; d < w; d++) begin
            string rv;
            string rl;
            @(negedge clk);
            if (d < 7) rv = "R4";
            else       rv = g[0] ? "R6" : "R5";
            if (mid && d > 3) rv = "R9";
            rl = mid ? "R7" : (nm ? "R2" : "R1");
            chk(rv, "video", video_o, pat[9-d]);
            chk("R3", "char_clk", char_clk_o, d == 0);
            chk(rl, "load", font_load_o, d == w - 1);
            if (mid && d == 3) begin
                glyph_i       = ~g;
                narrow_mode_i = ~nm;
            end
        end
    endtask

    // Entered on a negedge while in reset; releases and checks the blank cell.
    task automatic release_and_count();
        rst_n = 1'b1;
        for (int n = 1; n <= 9; n++) begin
            @(negedge clk);
            chk("R8", "load after reset", font_load_o, n == 9);
            chk("R8", "video after reset", video_o, 1'b0);
            chk("R8", "char_clk after reset", char_clk_o, 1'b0);
        end
    endtask

    initial begin
        rst_n         = 1'b0;
        narrow_mode_i = 1'b1;
        glyph_i       = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R8", "reset video", video_o, 1'b0);
        chk("R8", "reset load", font_load_o, 1'b0);
        chk("R8", "reset char_clk", char_clk_o, 1'b0);
        release_and_count();

        for (int i = 0; i < NVEC; i++) begin
            run_cell(VEC[i][18:11], VEC[i][10], VEC[i][9:0], 1'b0);
        end

        // R7 R9: flip mode and glyph at dot 3 of a wide then a narrow cell
        run_cell(8'hFE, 1'b0, 10'h3F8, 1'b1);
        run_cell(8'hAA, 1'b1, 10'h2A8, 1'b0);
        run_cell(8'h92, 1'b1, 10'h248, 1'b1);
        run_cell(8'h03, 1'b0, 10'h00F, 1'b0);

        // R8: reset part-way through a narrow cell
        glyph_i       = 8'hFF;
        narrow_mode_i = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8", "mid reset video", video_o, 1'b0);
        chk("R8", "mid reset load", font_load_o, 1'b0);
        chk("R8", "mid reset char_clk", char_clk_o, 1'b0);
        release_and_count();
        run_cell(8'h55, 1'b1, 10'h150, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule